// File: doc/BRIEF.md
# Streaming Constant Multiplier

This block is a free-running stream datapath that scales every 32-bit word passing through it by a coefficient. Software sets the coefficient through a small AXI4-Lite slave that holds one register. Words enter on an AXI4-Stream slave port and leave on an AXI4-Stream master port. Each accepted input beat produces exactly one output beat, and that beat carries the same end-of-packet and byte-qualifier sideband as the input.

No start, idle or done handshake exists. Beats are processed whenever they are offered and the output side can take them. The product leaves through one register stage. That register stalls the input while a held output beat waits on the downstream ready.

Top module: `stream_coef_mult`

## Requirements
- R1: After reset, out_tvalid is 0 and a read of the coefficient register returns 0.
- R2: The coefficient is a signed 32-bit register at word offset 0x10 (address bits [1:0] ignored). A write to it is returned unchanged by a later read, with OKAY (2'b00) on both responses.
- R3: Write strobe bit k enables byte k, which is data bits [8k+7:8k], of the coefficient register. Bytes whose strobe is 0 keep their previous value.
- R4: A write to any other offset completes with OKAY and leaves the coefficient unchanged. A read of any other offset completes with OKAY and returns 0.
- R5: Each output word is the low 32 bits of the signed product of the input word and the coefficient.
- R6: A beat accepted at a clock edge shows out_tvalid high after that same edge. With out_tready high, out_tvalid drops after the next edge.
- R7: out_tlast, out_tkeep and out_tstrb equal the tlast, tkeep and tstrb of the input beat that produced the output.
- R8: While out_tvalid is high and out_tready is low, the output beat stays stable and in_tready is low.
- R9: The number of output beats equals the number of accepted input beats. No beat is dropped or duplicated.
- R10: While the coefficient is still 0 from reset, every output word is 0.
- R11: A new coefficient applies to every beat accepted from the cycle its write response is raised onward. A beat already held in the output register keeps its old product.
- R12: No control action is needed to start processing. With out_tready high, in_tready stays high and a new beat is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| cfg_awaddr | input | 8 | Write address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address ready |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Write byte strobes |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data ready |
| cfg_bresp | output | 2 | Write response |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response ready |
| cfg_araddr | input | 8 | Read address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address ready |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data ready |
| in_tdata | input | 32 | Input stream data |
| in_tkeep | input | 4 | Input byte keep |
| in_tstrb | input | 4 | Input byte strobe |
| in_tlast | input | 1 | Input end of packet |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat ready |
| out_tdata | output | 32 | Output product |
| out_tkeep | output | 4 | Output byte keep |
| out_tstrb | output | 4 | Output byte strobe |
| out_tlast | output | 1 | Output end of packet |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Output beat ready |

## Verification
The bench uses negative coefficients and operands near the signed limits. A design that multiplies unsigned, or keeps the wrong half of the product, fails those cases. It stalls the output while a second beat waits at the input. A design that overwrites the held register or drops a beat is caught there. It also rewrites the coefficient while a beat sits in the output register. A design that recomputes the held beat, or applies the coefficient one beat late, is caught by that test. Partial-strobe writes and writes to an unmapped offset catch designs that merge bytes wrongly or decode addresses loosely.

// File: rtl/scm_pkg.sv
package scm_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } axil_resp_e;
endpackage

// File: rtl/scm_csr.sv
module scm_csr
    import scm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter logic [ADDR_W-1:0] COEF_OFS = 8'h10
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] coef
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] coef;
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } csr_state_t;

    csr_state_t state_d, state_q;
    logic [DATA_W-1:0] merged;
    logic wr_go, rd_go, wr_hit, rd_hit;

    // byte-lane merge of write data over the current coefficient
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[b*8 +: 8] = wstrb[b] ? wdata[b*8 +: 8] : state_q.coef[b*8 +: 8];
    end

    assign wr_go  = awvalid & wvalid & ~state_q.bvalid;
    assign rd_go  = arvalid & ~state_q.rvalid;
    assign wr_hit = awaddr[ADDR_W-1:2] == COEF_OFS[ADDR_W-1:2];
    assign rd_hit = araddr[ADDR_W-1:2] == COEF_OFS[ADDR_W-1:2];

    always_comb begin
        state_d = state_q;
        if (state_q.bvalid && bready) state_d.bvalid = 1'b0;
        if (wr_go) begin
            state_d.bvalid = 1'b1;
            if (wr_hit) state_d.coef = merged;
        end
        if (state_q.rvalid && rready) state_d.rvalid = 1'b0;
        if (rd_go) begin
            state_d.rvalid = 1'b1;
            state_d.rdata  = rd_hit ? state_q.coef : '0;
        end
    end

    always_ff @(posedge aclk) begin
        if (!aresetn) state_q <= '0;
        else          state_q <= state_d;
    end

    assign awready = wr_go;
    assign wready  = wr_go;
    assign bvalid  = state_q.bvalid;
    assign bresp   = RESP_OKAY;
    assign arready = rd_go;
    assign rvalid  = state_q.rvalid;
    assign rdata   = state_q.rdata;
    assign rresp   = RESP_OKAY;
    assign coef    = state_q.coef;
endmodule

// File: rtl/scm_mul_stage.sv
module scm_mul_stage #(
    parameter int DATA_W = 32,
    parameter int KEEP_W = DATA_W / 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [DATA_W-1:0] coef,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic [KEEP_W-1:0] in_tkeep,
    input  logic [KEEP_W-1:0] in_tstrb,
    input  logic              in_tlast,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic [KEEP_W-1:0] out_tkeep,
    output logic [KEEP_W-1:0] out_tstrb,
    output logic              out_tlast,
    output logic              out_tvalid,
    input  logic              out_tready
);
    localparam int PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic [KEEP_W-1:0] strb;
        logic              last;
    } beat_t;

    beat_t stage_d, stage_q;
    logic signed [PROD_W-1:0] op_a, op_b, prod;
    logic take;

    assign op_a = PROD_W'($signed(in_tdata));
    assign op_b = PROD_W'($signed(coef));
    assign prod = op_a * op_b;

    assign in_tready = ~stage_q.valid | out_tready;
    assign take      = in_tvalid & in_tready;

    always_comb begin
        stage_d = stage_q;
        if (take) begin
            stage_d.valid = 1'b1;
            stage_d.data  = prod[DATA_W-1:0];
            stage_d.keep  = in_tkeep;
            stage_d.strb  = in_tstrb;
            stage_d.last  = in_tlast;
        end else if (out_tready) begin
            stage_d.valid = 1'b0;
        end
    end

    always_ff @(posedge aclk) begin
        if (!aresetn) stage_q <= '0;
        else          stage_q <= stage_d;
    end

    assign out_tvalid = stage_q.valid;
    assign out_tdata  = stage_q.data;
    assign out_tkeep  = stage_q.keep;
    assign out_tstrb  = stage_q.strb;
    assign out_tlast  = stage_q.last;
endmodule

// File: rtl/stream_coef_mult.sv
module stream_coef_mult #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] COEF_OFS = 8'h10,
    localparam int KEEP_W = DATA_W / 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] cfg_awaddr,
    input  logic              cfg_awvalid,
    output logic              cfg_awready,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [KEEP_W-1:0] cfg_wstrb,
    input  logic              cfg_wvalid,
    output logic              cfg_wready,
    output logic [1:0]        cfg_bresp,
    output logic              cfg_bvalid,
    input  logic              cfg_bready,
    input  logic [ADDR_W-1:0] cfg_araddr,
    input  logic              cfg_arvalid,
    output logic              cfg_arready,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [1:0]        cfg_rresp,
    output logic              cfg_rvalid,
    input  logic              cfg_rready,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic [KEEP_W-1:0] in_tkeep,
    input  logic [KEEP_W-1:0] in_tstrb,
    input  logic              in_tlast,
    input  logic              in_tvalid,
    output logic              in_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic [KEEP_W-1:0] out_tkeep,
    output logic [KEEP_W-1:0] out_tstrb,
    output logic              out_tlast,
    output logic              out_tvalid,
    input  logic              out_tready
);
    logic [DATA_W-1:0] coef_w;

    scm_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COEF_OFS(COEF_OFS)) u_csr (
        .aclk(aclk), .aresetn(aresetn),
        .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
        .wdata(cfg_wdata), .wstrb(cfg_wstrb), .wvalid(cfg_wvalid), .wready(cfg_wready),
        .bresp(cfg_bresp), .bvalid(cfg_bvalid), .bready(cfg_bready),
        .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
        .rdata(cfg_rdata), .rresp(cfg_rresp), .rvalid(cfg_rvalid), .rready(cfg_rready),
        .coef(coef_w)
    );

    scm_mul_stage #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_mul (
        .aclk(aclk), .aresetn(aresetn), .coef(coef_w),
        .in_tdata(in_tdata), .in_tkeep(in_tkeep), .in_tstrb(in_tstrb),
        .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
        .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tstrb(out_tstrb),
        .out_tlast(out_tlast), .out_tvalid(out_tvalid), .out_tready(out_tready)
    );
endmodule

// File: rtl/scm_checker.sv
module scm_checker #(
    parameter int DATA_W = 32,
    parameter int KEEP_W = DATA_W / 8
) (
    input logic              aclk,
    input logic              aresetn,
    input logic [DATA_W-1:0] coef,
    input logic [DATA_W-1:0] in_tdata,
    input logic [KEEP_W-1:0] in_tkeep,
    input logic [KEEP_W-1:0] in_tstrb,
    input logic              in_tlast,
    input logic              in_tvalid,
    input logic              in_tready,
    input logic [DATA_W-1:0] out_tdata,
    input logic [KEEP_W-1:0] out_tkeep,
    input logic [KEEP_W-1:0] out_tstrb,
    input logic              out_tlast,
    input logic              out_tvalid,
    input logic              out_tready,
    input logic              bvalid,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic [1:0]        rresp
);
    p_product_r5: assert property (@(posedge aclk) disable iff (!aresetn)
        (in_tvalid && in_tready) |=> out_tdata == ($past(in_tdata) * $past(coef)));

    p_latency_r6: assert property (@(posedge aclk) disable iff (!aresetn)
        (in_tvalid && in_tready) |=> out_tvalid);

    p_sideband_r7: assert property (@(posedge aclk) disable iff (!aresetn)
        (in_tvalid && in_tready) |=> (out_tlast == $past(in_tlast)) &&
            (out_tkeep == $past(in_tkeep)) && (out_tstrb == $past(in_tstrb)));

    p_hold_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        (out_tvalid && !out_tready) |=> out_tvalid && $stable(out_tdata) &&
            $stable(out_tlast) && $stable(out_tkeep) && $stable(out_tstrb));

    p_stall_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        (out_tvalid && !out_tready) |-> !in_tready);

    p_bresp_okay_r4: assert property (@(posedge aclk) disable iff (!aresetn)
        bvalid |-> bresp == 2'b00);

    p_rresp_okay_r4: assert property (@(posedge aclk) disable iff (!aresetn)
        rvalid |-> rresp == 2'b00);
endmodule

bind stream_coef_mult scm_checker #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
    .aclk(aclk), .aresetn(aresetn), .coef(coef_w),
    .in_tdata(in_tdata), .in_tkeep(in_tkeep), .in_tstrb(in_tstrb),
    .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tstrb(out_tstrb),
    .out_tlast(out_tlast), .out_tvalid(out_tvalid), .out_tready(out_tready),
    .bvalid(cfg_bvalid), .bresp(cfg_bresp), .rvalid(cfg_rvalid), .rresp(cfg_rresp)
);

// File: tb/tb_stream_coef_mult.sv
module tb_stream_coef_mult;
    logic aclk = 1'b0;
    logic aresetn = 1'b0;
    always #10 aclk = ~aclk;

    logic [7:0]  cfg_awaddr = '0;  logic cfg_awvalid = 1'b0; logic cfg_awready;
    logic [31:0] cfg_wdata = '0;   logic [3:0] cfg_wstrb = '0;
    logic cfg_wvalid = 1'b0;       logic cfg_wready;
    logic [1:0]  cfg_bresp;        logic cfg_bvalid; logic cfg_bready = 1'b1;
    logic [7:0]  cfg_araddr = '0;  logic cfg_arvalid = 1'b0; logic cfg_arready;
    logic [31:0] cfg_rdata;        logic [1:0] cfg_rresp;
    logic cfg_rvalid;              logic cfg_rready = 1'b1;
    logic [31:0] in_tdata = '0;    logic [3:0] in_tkeep = '0; logic [3:0] in_tstrb = '0;
    logic in_tlast = 1'b0;         logic in_tvalid = 1'b0; logic in_tready;
    logic [31:0] out_tdata;        logic [3:0] out_tkeep; logic [3:0] out_tstrb;
    logic out_tlast;               logic out_tvalid; logic out_tready = 1'b1;

    stream_coef_mult dut (.*);

    int n_tests = 0;
    int n_fail = 0;

    logic [31:0] cap_data [0:255];
    logic [3:0]  cap_keep [0:255];
    logic [3:0]  cap_strb [0:255];
    logic        cap_last [0:255];
    int cap_n = 0;

    always @(negedge aclk) begin
        #5;
        if (aresetn && out_tvalid && out_tready) begin
            cap_data[cap_n] = out_tdata;
            cap_keep[cap_n] = out_tkeep;
            cap_strb[cap_n] = out_tstrb;
            cap_last[cap_n] = out_tlast;
            cap_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mul32(input logic [31:0] a, input logic [31:0] c);
        longint p;
        p = longint'($signed(a)) * longint'($signed(c));
        return p[31:0];
    endfunction

    task automatic reg_write(input logic [7:0] addr, input logic [31:0] data,
                             input logic [3:0] strb, output logic [1:0] resp);
        @(negedge aclk);
        cfg_awaddr = addr; cfg_wdata = data; cfg_wstrb = strb;
        cfg_awvalid = 1'b1; cfg_wvalid = 1'b1;
        #1;
        while (!cfg_awready) begin @(negedge aclk); #1; end
        @(posedge aclk); #1;
        cfg_awvalid = 1'b0; cfg_wvalid = 1'b0;
        @(negedge aclk);
        resp = cfg_bvalid ? cfg_bresp : 2'b11;
    endtask

    task automatic reg_read(input logic [7:0] addr, output logic [31:0] data,
                            output logic [1:0] resp);
        @(negedge aclk);
        cfg_araddr = addr; cfg_arvalid = 1'b1;
        #1;
        while (!cfg_arready) begin @(negedge aclk); #1; end
        @(posedge aclk); #1;
        cfg_arvalid = 1'b0;
        @(negedge aclk);
        data = cfg_rdata;
        resp = cfg_rvalid ? cfg_rresp : 2'b11;
    endtask

    task automatic send(input logic [31:0] d, input logic [3:0] k,
                        input logic [3:0] s, input logic l);
        @(negedge aclk);
        in_tdata = d; in_tkeep = k; in_tstrb = s; in_tlast = l; in_tvalid = 1'b1;
        #1;
        while (!in_tready) begin @(negedge aclk); #1; end
        @(posedge aclk); #1;
        in_tvalid = 1'b0;
    endtask

    task automatic set_coef(input logic [31:0] c);
        logic [1:0] r;
        reg_write(8'h10, c, 4'hF, r);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r; int base;
        check("R1 out_tvalid after reset", {31'b0, out_tvalid}, 32'd0);
        reg_read(8'h10, d, r);
        check("R1 coef after reset", d, 32'd0);
        base = cap_n;
        send(32'd7, 4'hF, 4'hF, 1'b1);
        repeat (3) @(negedge aclk);
        check("R9 beat count zero coef", cap_n - base, 32'd1);
        check("R10 zero coef output", cap_data[base], 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d; logic [1:0] r;
        reg_write(8'h10, 32'd5, 4'hF, r);
        check("R2 write response", {30'b0, r}, 32'd0);
        reg_read(8'h10, d, r);
        check("R2 readback", d, 32'd5);
        check("R2 read response", {30'b0, r}, 32'd0);
        reg_write(8'h10, 32'hFFFFFFFD, 4'hF, r);
        reg_read(8'h10, d, r);
        check("R2 signed readback", d, 32'hFFFFFFFD);
    endtask

    task automatic t_strobe();
        logic [31:0] d; logic [1:0] r;
        reg_write(8'h10, 32'h11223344, 4'hF, r);
        reg_write(8'h10, 32'hAABBCCDD, 4'b0101, r);
        reg_read(8'h10, d, r);
        check("R3 partial strobes", d, 32'h11BB33DD);
    endtask

    task automatic t_other();
        logic [31:0] d; logic [1:0] r;
        reg_write(8'h14, 32'hDEADBEEF, 4'hF, r);
        check("R4 other write resp", {30'b0, r}, 32'd0);
        reg_read(8'h14, d, r);
        check("R4 other read data", d, 32'd0);
        check("R4 other read resp", {30'b0, r}, 32'd0);
        reg_read(8'h10, d, r);
        check("R4 coef untouched", d, 32'h11BB33DD);
        reg_read(8'h00, d, r);
        check("R4 offset 0 read", d, 32'd0);
    endtask

    task automatic t_basic();
        int base;
        set_coef(32'd5);
        base = cap_n;
        for (int i = 0; i < 6; i++)
            send(32'(i), 4'(i * 3), 4'(~i), (i == 2) || (i == 5));
        repeat (3) @(negedge aclk);
        check("R9 beat count packet", cap_n - base, 32'd6);
        for (int i = 0; i < 6; i++) begin
            check("R5 product", cap_data[base + i], 32'(5 * i));
            check("R7 tkeep", {28'b0, cap_keep[base + i]}, {28'b0, 4'(i * 3)});
            check("R7 tstrb", {28'b0, cap_strb[base + i]}, {28'b0, 4'(~i)});
            check("R7 tlast", {31'b0, cap_last[base + i]}, {31'b0, (i == 2) || (i == 5)});
        end
    endtask

    task automatic t_signed();
        logic [31:0] ins [4];
        int base;
        ins[0] = 32'd7; ins[1] = 32'h7FFFFFFF; ins[2] = 32'h80000000; ins[3] = 32'h12345678;
        set_coef(32'hFFFFFFFD);
        base = cap_n;
        for (int i = 0; i < 4; i++) send(ins[i], 4'hF, 4'hF, 1'b0);
        repeat (3) @(negedge aclk);
        for (int i = 0; i < 4; i++)
            check("R5 signed truncated product", cap_data[base + i], mul32(ins[i], 32'hFFFFFFFD));
        set_coef(32'h00012345);
        base = cap_n;
        send(32'hFFFF0001, 4'hF, 4'hF, 1'b0);
        repeat (3) @(negedge aclk);
        check("R5 wide truncation", cap_data[base], mul32(32'hFFFF0001, 32'h00012345));
    endtask

    task automatic t_latency();
        set_coef(32'd9);
        @(negedge aclk);
        in_tdata = 32'd4; in_tkeep = 4'hF; in_tstrb = 4'hF; in_tlast = 1'b0; in_tvalid = 1'b1;
        #1;
        check("R6 idle before accept", {31'b0, out_tvalid}, 32'd0);
        @(posedge aclk); #1;
        in_tvalid = 1'b0;
        check("R6 valid after accept edge", {31'b0, out_tvalid}, 32'd1);
        check("R6 data after accept edge", out_tdata, 32'd36);
        @(posedge aclk); #1;
        check("R6 valid drops", {31'b0, out_tvalid}, 32'd0);
    endtask

    task automatic t_backpressure();
        int base;
        set_coef(32'd2);
        base = cap_n;
        @(negedge aclk); out_tready = 1'b0;
        send(32'd100, 4'h3, 4'h1, 1'b0);
        @(negedge aclk);
        in_tdata = 32'd200; in_tkeep = 4'hF; in_tstrb = 4'hF; in_tlast = 1'b1; in_tvalid = 1'b1;
        #1;
        for (int i = 0; i < 3; i++) begin
            check("R8 input stalled", {31'b0, in_tready}, 32'd0);
            check("R8 output held", out_tdata, 32'd200);
            check("R8 keep held", {28'b0, out_tkeep}, 32'h3);
            @(negedge aclk); #1;
        end
        out_tready = 1'b1;
        @(posedge aclk); #1;
        in_tvalid = 1'b0;
        repeat (3) @(negedge aclk);
        check("R9 count after stall", cap_n - base, 32'd2);
        check("R8 first after stall", cap_data[base], 32'd200);
        check("R8 second after stall", cap_data[base + 1], 32'd400);
        check("R7 last after stall", {31'b0, cap_last[base + 1]}, 32'd1);
    endtask

    task automatic t_coef_change();
        int base;
        set_coef(32'd2);
        base = cap_n;
        @(negedge aclk); out_tready = 1'b0;
        send(32'd10, 4'hF, 4'hF, 1'b0);
        set_coef(32'd3);
        #1;
        check("R11 held beat not recomputed", out_tdata, 32'd20);
        @(negedge aclk); out_tready = 1'b1;
        send(32'd10, 4'hF, 4'hF, 1'b0);
        repeat (3) @(negedge aclk);
        check("R11 count", cap_n - base, 32'd2);
        check("R11 old product", cap_data[base], 32'd20);
        check("R11 new coef applied", cap_data[base + 1], 32'd30);
    endtask

    task automatic t_free_run();
        int base;
        set_coef(32'd7);
        base = cap_n;
        for (int i = 0; i < 4; i++) begin
            @(negedge aclk);
            in_tdata = 32'(i + 1); in_tkeep = 4'hF; in_tstrb = 4'hF;
            in_tlast = (i == 3); in_tvalid = 1'b1;
            #1;
            check("R12 ready every cycle", {31'b0, in_tready}, 32'd1);
        end
        @(negedge aclk); in_tvalid = 1'b0;
        repeat (3) @(negedge aclk);
        check("R12 back-to-back count", cap_n - base, 32'd4);
        for (int i = 0; i < 4; i++)
            check("R12 back-to-back data", cap_data[base + i], 32'(7 * (i + 1)));
    endtask

    initial begin
        repeat (3) @(negedge aclk);
        aresetn = 1'b1;
        t_reset();
        t_regs();
        t_strobe();
        t_other();
        t_basic();
        t_signed();
        t_latency();
        t_backpressure();
        t_coef_change();
        t_free_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge aclk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule